// File: doc/BRIEF.md
# Serial DMA Request Encoder

This block watches a set of parallel DMA request lines from local DMA devices and reports changes on them to the bus host over a single active-low serial wire. The wire is clocked on the bus clock. Each report is a short frame that names one channel and gives its new request level. The encoder keeps the last level it reported for every channel. A channel needs a new frame only when its live input differs from that stored level, or when the bus target has asked for the request to be repeated.

Frames for different channels may run one directly after another. Two frames for the same channel are kept at least four idle clocks apart, so that each level stays visible long enough for a slow downstream DMA controller to sample it. After a DMA cycle is cut short to a single byte, the bus target pulses a re-issue input for that channel. This makes the encoder send the asserted request again.

Top module: `dreq_serial_encoder`

## Requirements
- R1: A frame lasts six clocks on `dreq_ser_n`, in this order: a start bit of 0, the channel number as a 3-bit field sent most significant bit first, the level bit (1 = requesting), and a stop bit of 1.
- R2: After reset every channel is taken as not requesting, and `dreq_ser_n` stays 1 until some request input changes. Between frames the line is 1.
- R3: A channel whose request input differs from its last reported level gets a frame. The level bit carries that input's value in the clock before the start bit. When the line is idle, the start bit comes one clock after the input changes.
- R4: If another channel is ready when a frame ends, its start bit follows the stop bit with no idle clock.
- R5: The next start bit for a channel comes no earlier than five clocks after that channel's stop bit. That leaves at least four idle clocks for the channel. When nothing else is queued, the gap is exactly four.
- R6: Among the channels that are ready, the lowest index is sent first. A channel still inside its spacing window is skipped, and a ready higher-index channel is sent in its place.
- R7: If an input returns to its reported level before its frame has started, no frame is sent for that change.
- R8: A re-issue pulse for a channel whose request input is 1 causes one extra frame with level 1. A pulse for a channel whose input is 0 is ignored.
- R9: The reported level changes only when a frame completes. An input change during a frame for the same channel leads to a further frame after the spacing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NUM_CH | Parallel DMA request levels, one per channel |
| reissue_in | input | NUM_CH | One-clock pulses asking that a channel's asserted request be sent again |
| dreq_ser_n | output | 1 | Serial request frames; idles high |

## Verification
The bench goes after four kinds of mistake. It toggles a channel during its own frame: a design that updated the stored level at frame start, or that did not space frames, would lose the second frame or send it too early. It raises a high-priority channel that is still in its spacing window together with a lower-priority one: a strict priority arbiter that ignored the window would stall, or would send the same channel twice too close together. It pulses a short glitch on a waiting channel and expects no frame, because a design that latched the change would report a stale level. It sends re-issue pulses to a low channel, where a design that did not gate them would emit a false asserted frame. A long random run then checks that every frame is well formed, that every level bit matches the input, that spacing holds, and that the reported levels settle onto the inputs.

// File: rtl/ldrq_enc_pkg.sv
`timescale 1ns/1ps
package ldrq_enc_pkg;
  localparam int unsigned FIELD_W   = 3;
  localparam int unsigned FRAME_LEN = 6;
  localparam int unsigned IDX_W     = 3;

  // Serial value of one frame position: start, channel msb..lsb, level, stop.
  function automatic logic frame_bit(input logic [FIELD_W-1:0] ch,
                                     input logic lvl,
                                     input logic [IDX_W-1:0] idx);
    logic b;
    case (idx)
      3'd0:    b = 1'b0;
      3'd1:    b = ch[2];
      3'd2:    b = ch[1];
      3'd3:    b = ch[0];
      3'd4:    b = lvl;
      default: b = 1'b1;
    endcase
    return b;
  endfunction

  // The counter is loaded at the stop bit and released when it reaches zero.
  function automatic int unsigned gap_reload(input int unsigned gap_clks);
    return (gap_clks == 0) ? 0 : gap_clks - 1;
  endfunction
endpackage

// File: rtl/ldrq_chan_track.sv
`timescale 1ns/1ps
module ldrq_chan_track #(
  parameter int unsigned GAP_CLKS = 4,
  parameter int unsigned GAP_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic reissue,
  input  logic start,
  input  logic active,
  input  logic done,
  input  logic sent_lvl,
  output logic pending,
  output logic eligible,
  output logic reported
);
  import ldrq_enc_pkg::*;
  localparam logic [GAP_W-1:0] RELOAD = GAP_W'(gap_reload(GAP_CLKS));

  logic [GAP_W-1:0] gap_cnt;
  logic             rflag;
  logic             in_gap;

  assign in_gap   = (gap_cnt != '0);
  assign pending  = (req != reported) | rflag;
  assign eligible = pending & ~in_gap & ~active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reported <= 1'b0;
      gap_cnt  <= '0;
    end else if (done) begin
      reported <= sent_lvl;
      gap_cnt  <= RELOAD;
    end else if (in_gap) begin
      gap_cnt  <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              rflag <= 1'b0;
    else if (reissue && req) rflag <= 1'b1;
    else if (done)           rflag <= 1'b0;
  end

  a_r5_start_outside_gap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_gap);
  a_r8_reissue_cleared_by_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rflag) |-> $past(done));
  a_r9_reported_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(reported));
endmodule

// File: rtl/ldrq_prio_pick.sv
`timescale 1ns/1ps
module ldrq_prio_pick #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] elig,
  output logic [NUM_CH-1:0] grant,
  output logic              any
);
  logic [NUM_CH-1:0] lower_ready;

  assign lower_ready[0] = 1'b0;
  for (genvar i = 1; i < NUM_CH; i++) begin : g_prefix
    assign lower_ready[i] = lower_ready[i-1] | elig[i-1];
  end

  assign grant = elig & ~lower_ready;
  assign any   = |elig;

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r6_grant_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (grant != '0));
  for (genvar i = 1; i < NUM_CH; i++) begin : g_prio_chk
    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (elig[i-1:0] == '0));
  end
endmodule

// File: rtl/ldrq_frame_shifter.sv
`timescale 1ns/1ps
module ldrq_frame_shifter #(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_ch,
  input  logic            load_lvl,
  output logic            ser_n,
  output logic            busy,
  output logic            last,
  output logic [CH_W-1:0] cur_ch,
  output logic            cur_lvl
);
  import ldrq_enc_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0] idx;

  assign last  = busy && (idx == LAST_IDX);
  assign ser_n = busy ? frame_bit(FIELD_W'(cur_ch), cur_lvl, idx) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      cur_ch  <= '0;
      cur_lvl <= 1'b0;
    end else if (load) begin
      busy    <= 1'b1;
      idx     <= '0;
      cur_ch  <= load_ch;
      cur_lvl <= load_lvl;
    end else if (last) begin
      busy    <= 1'b0;
      idx     <= '0;
    end else if (busy) begin
      idx     <= idx + 1'b1;
    end
  end

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_n);
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == '0) |-> !ser_n);
  a_r1_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> ser_n);
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (last && load) |=> (busy && !ser_n));
endmodule

// File: rtl/dreq_serial_encoder.sv
`timescale 1ns/1ps
module dreq_serial_encoder #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned GAP_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_in,
  input  logic [NUM_CH-1:0] reissue_in,
  output logic              dreq_ser_n
);
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned GAP_W = (GAP_CLKS > 1) ? $clog2(GAP_CLKS + 1) : 1;

  logic [NUM_CH-1:0] pending, eligible, reported, grant, done_v, active_v, start_v;
  logic              any_ready, can_load, load;
  logic              busy, last, cur_lvl, pick_lvl;
  logic [CH_W-1:0]   cur_ch, pick_ch;

  ldrq_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(eligible), .grant(grant), .any(any_ready)
  );

  assign can_load = !busy || last;
  assign load     = any_ready && can_load;

  always_comb begin
    pick_ch  = '0;
    pick_lvl = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant[i]) begin
        pick_ch  = CH_W'(i);
        pick_lvl = req_in[i];
      end
    end
  end

  ldrq_frame_shifter #(.CH_W(CH_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_ch(pick_ch), .load_lvl(pick_lvl),
    .ser_n(dreq_ser_n), .busy(busy), .last(last), .cur_ch(cur_ch), .cur_lvl(cur_lvl)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    assign active_v[i] = busy && (cur_ch == CH_W'(i));
    assign done_v[i]   = last && (cur_ch == CH_W'(i));
    assign start_v[i]  = load && grant[i];

    ldrq_chan_track #(.GAP_CLKS(GAP_CLKS), .GAP_W(GAP_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .req(req_in[i]), .reissue(reissue_in[i]),
      .start(start_v[i]), .active(active_v[i]), .done(done_v[i]), .sent_lvl(cur_lvl),
      .pending(pending[i]), .eligible(eligible[i]), .reported(reported[i])
    );
  end

  a_r2_quiet_without_work: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !load);
  a_r3_idle_starts_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && any_ready) |=> !dreq_ser_n);
endmodule

// File: tb/sim_dreq_serial_encoder.sv
`timescale 1ns/1ps
module sim_dreq_serial_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_in = 4'b0000;
  logic [3:0] reissue_in = 4'b0000;
  logic       dreq_ser_n;

  always #5 clk = ~clk;

  dreq_serial_encoder #(.NUM_CH(4), .GAP_CLKS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .reissue_in(reissue_in),
    .dreq_ser_n(dreq_ser_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Frame decoder
  int cyc = 0;
  logic [3:0] req_prev = 4'b0000;
  bit   in_frame = 0;
  int   bitn = 0;
  int   f_start = 0;
  logic [2:0] f_ch = 3'd0;
  logic f_lvl = 1'b0;
  logic [3:0] f_exp = 4'b0000;
  int   nfr = 0;
  int   fr_ch[64];
  int   fr_lvl[64];
  int   fr_start[64];
  int   last_end[4] = '{-1000, -1000, -1000, -1000};
  logic [3:0] dec_lvl = 4'b0000;

  // Spacing window in clocks: stop bit to next start of the same channel.
  function automatic int min_same_gap();
    return 4 + 1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!in_frame) begin
        if (dreq_ser_n == 1'b0) begin
          in_frame = 1; bitn = 1; f_start = cyc; f_exp = req_prev; f_ch = 3'd0;
        end
      end else begin
        if (bitn <= 3) f_ch = {f_ch[1:0], dreq_ser_n};
        else if (bitn == 4) f_lvl = dreq_ser_n;
        else begin
          chk(dreq_ser_n == 1'b1, "R1 stop bit", int'(dreq_ser_n), 1);
          chk(f_ch < 3'd4, "R1 channel field", int'(f_ch), 3);
          if (f_ch < 3'd4) begin
            chk(f_lvl == f_exp[f_ch[1:0]], "R3 level bit", int'(f_lvl), int'(f_exp[f_ch[1:0]]));
            chk(f_start - last_end[f_ch[1:0]] >= min_same_gap(), "R5 same-channel spacing",
                f_start - last_end[f_ch[1:0]], min_same_gap());
            last_end[f_ch[1:0]] = cyc;
            dec_lvl[f_ch[1:0]] = f_lvl;
          end
          fr_ch[nfr % 64] = int'(f_ch);
          fr_lvl[nfr % 64] = int'(f_lvl);
          fr_start[nfr % 64] = f_start;
          nfr++;
          in_frame = 0;
        end
        bitn++;
      end
    end
    req_prev = req_in;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic drv(input logic [3:0] v);
    @(posedge clk); #2 req_in = v;
  endtask

  task automatic pulse(input logic [3:0] v);
    @(posedge clk); #2 reissue_in = v;
    @(posedge clk); #2 reissue_in = 4'b0000;
  endtask

  task automatic wait_start();
    while (dreq_ser_n) tick(1);
  endtask

  task automatic expect_frame(input int k, input int ch, input int lvl, input string tag);
    chk(fr_ch[k % 64] == ch, {tag, " channel"}, fr_ch[k % 64], ch);
    chk(fr_lvl[k % 64] == lvl, {tag, " level"}, fr_lvl[k % 64], lvl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    int unsigned r;
    r = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;

    // R2: quiet after reset
    tick(20);
    chk(dreq_ser_n == 1'b1, "R2 idle line", int'(dreq_ser_n), 1);
    chk(nfr == 0, "R2 no frames after reset", nfr, 0);

    // R3: single change, latency one clock when idle
    base = nfr;
    drv(4'b0100);
    tick(1);
    chk(dreq_ser_n == 1'b1, "R3 not yet started", int'(dreq_ser_n), 1);
    tick(1);
    chk(dreq_ser_n == 1'b0, "R3 start bit next clock", int'(dreq_ser_n), 0);
    tick(40);
    chk(nfr == base + 1, "R3 frame count", nfr - base, 1);
    expect_frame(base, 2, 1, "R3 ch2 up");

    // R4 and R6: two channels at once, lowest first, back to back
    base = nfr;
    drv(4'b1110);
    tick(40);
    chk(nfr == base + 2, "R4 frame count", nfr - base, 2);
    expect_frame(base, 1, 1, "R6 ch1 first");
    expect_frame(base + 1, 3, 1, "R6 ch3 second");
    chk(fr_start[(base + 1) % 64] - fr_start[base % 64] == 6, "R4 no gap",
        fr_start[(base + 1) % 64] - fr_start[base % 64], 6);

    // R5 and R9: change during own frame, resent after exactly four idle clocks
    base = nfr;
    drv(4'b1111);
    wait_start();
    drv(4'b1110);
    tick(40);
    chk(nfr == base + 2, "R9 second frame", nfr - base, 2);
    expect_frame(base, 0, 1, "R9 first");
    expect_frame(base + 1, 0, 0, "R9 newest level");
    chk(fr_start[(base + 1) % 64] - fr_start[base % 64] == 10, "R5 exact gap",
        fr_start[(base + 1) % 64] - fr_start[base % 64], 10);

    // R6: channel in window skipped in favour of a higher index
    base = nfr;
    drv(4'b1111);
    wait_start();
    drv(4'b1010);
    tick(50);
    chk(nfr == base + 3, "R6 skip frame count", nfr - base, 3);
    expect_frame(base, 0, 1, "R6 ch0 up");
    expect_frame(base + 1, 2, 0, "R6 ch2 skips ahead");
    expect_frame(base + 2, 0, 0, "R6 ch0 after window");
    chk(fr_start[(base + 1) % 64] - fr_start[base % 64] == 6, "R6 ch2 start",
        fr_start[(base + 1) % 64] - fr_start[base % 64], 6);
    chk(fr_start[(base + 2) % 64] - fr_start[base % 64] == 12, "R6 ch0 resend start",
        fr_start[(base + 2) % 64] - fr_start[base % 64], 12);

    // R7: glitch reverted while waiting produces nothing
    base = nfr;
    drv(4'b1011);
    wait_start();
    drv(4'b1111);
    drv(4'b1011);
    tick(40);
    chk(nfr == base + 1, "R7 glitch dropped", nfr - base, 1);
    expect_frame(base, 0, 1, "R7 ch0 up");

    // R8: re-issue on a high channel, ignored on a low channel
    base = nfr;
    pulse(4'b0010);
    tick(40);
    chk(nfr == base + 1, "R8 re-issue frame", nfr - base, 1);
    expect_frame(base, 1, 1, "R8 re-issue ch1");
    base = nfr;
    pulse(4'b0100);
    tick(40);
    chk(nfr == base, "R8 low channel ignored", nfr - base, 0);
    chk(dreq_ser_n == 1'b1, "R8 line idle", int'(dreq_ser_n), 1);

    // Random phase
    base = nfr;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      reissue_in = 4'b0000;
      r = $urandom();
      if (r[2:0] == 3'd0) req_in[r[5:4]] = ~req_in[r[5:4]];
      if (r[11:8] == 4'd0) reissue_in = 4'b0001 << r[13:12];
    end
    @(posedge clk); #2 reissue_in = 4'b0000;
    tick(100);
    chk(nfr > base, "R3 random frames seen", nfr - base, 1);
    for (int c = 0; c < 4; c++)
      chk(dec_lvl[c] == req_in[c], "R3 settled level", int'(dec_lvl[c]), int'(req_in[c]));
    chk(dreq_ser_n == 1'b1, "R2 idle after random", int'(dreq_ser_n), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule